// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block saves a processor's context on a byte-wide stack when an interrupt is taken and restores it when a return-from-interrupt is requested. It has one synchronous single-port memory interface: a write strobe, a read strobe, an address, write data and read data. It moves exactly one byte per clock. It owns the stack pointer. Software, or a surrounding control unit, can load that pointer while no sequence is running.

A mode input picks the frame format when each sequence starts. The short frame holds only the low 16 bits of the program counter. On return, the upper address byte is forced to a fixed region value. The long frame also holds the upper program counter byte and the status byte, in a non-obvious order, so a return can land anywhere in a 24-bit space. When a return completes, the rebuilt address and status are reported together with a one-cycle done pulse.

Top module: `ctx_stack_seq`

## Requirements
- R1: Short frame (mode 0) save: exactly two writes. The first writes pc[7:0] at SP+1. The second writes pc[15:8] at SP+2. SP ends 2 higher.
- R2: Short frame return: two reads, first at SP and then at SP-1. The first byte read becomes ret_pc[15:8] and the second becomes ret_pc[7:0]. ret_pc[23:16] is 0xFF whatever the saved pc[23:16] was. ret_status equals status_in as sampled with the return request.
- R3: Long frame (mode 1) save: four writes at SP+1..SP+4, in this order: status, pc[23:16], pc[7:0], pc[15:8]. SP ends 4 higher.
- R4: Long frame return: four reads from SP downward, taken as pc[15:8], pc[7:0], pc[23:16], then status. ret_pc is the full 24-bit saved address and ret_status is the saved status byte.
- R5: SP is incremented in the same cycle as each write, so each write lands one above the old SP. SP is decremented with each read, and each read uses the current SP. Read data is taken one cycle after the read strobe. The write and read strobes are never high together.
- R6: busy is high for every cycle of a sequence: N cycles for an N-byte save and N+1 cycles for an N-byte return. done is a single-cycle pulse in the cycle after busy falls. ret_pc and ret_status are valid while done is high after a return.
- R7: irq_take and reti_req are ignored while busy, so SP and the number of accesses are unchanged by them. mode_sel is sampled only when a sequence starts. If both requests arrive in the same idle cycle, the save is performed.
- R8: SP resets to 0x0007. sp_load loads sp_load_val when idle and no request is present. sp_load has no effect while busy or when a request arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Start a context save |
| reti_req | input | 1 | Start a context restore |
| mode_sel | input | 1 | Frame format: 0 short, 1 long |
| pc_in | input | 24 | Program counter to save |
| status_in | input | 8 | Status byte to save |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 16 | Value for the stack pointer load |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Stack read data, one cycle after mem_re |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ret_pc | output | 24 | Rebuilt resume address |
| ret_status | output | 8 | Restored status byte |

## Verification
The hardest case to reach is a stack holding frames of both formats nested inside each other. Each return must then unwind with the format its own frame was saved in, not the format of the latest save. The stimulus saves a short frame whose upper pc byte is non-0xFF, then saves a long frame on top of it. It then returns twice, selecting the matching mode each time. The test checks that the long return brings back all 24 bits and that the short return still yields 0xFF in the top byte. Requests and SP loads that arrive mid-sequence are injected on specific busy cycles. The resulting SP and the access count are then compared with the undisturbed values.

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq #(
  parameter int              SP_W       = 16,
  parameter logic [SP_W-1:0] SP_RESET   = SP_W'(7),
  parameter logic [7:0]      FIXED_PAGE = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_take,
  input  logic            reti_req,
  input  logic            mode_sel,
  input  logic [23:0]     pc_in,
  input  logic [7:0]      status_in,
  input  logic            sp_load,
  input  logic [SP_W-1:0] sp_load_val,
  output logic            mem_we,
  output logic            mem_re,
  output logic [SP_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  output logic [SP_W-1:0] sp_out,
  output logic            busy,
  output logic            done,
  output logic [23:0]     ret_pc,
  output logic [7:0]      ret_status
);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} state_t;

  state_t          state;
  logic            mode_q;
  logic [SP_W-1:0] sp;
  logic [2:0]      cnt;
  logic [23:0]     pc_q;
  logic [7:0]      st_q;
  logic            rv;
  logic [1:0]      ridx;
  logic [7:0]      b_hi, b_lo, b_up, b_st;
  logic            done_q;

  logic [1:0] last_idx;
  logic       issue;

  assign last_idx = mode_q ? 2'd3 : 2'd1;
  assign issue    = (state == S_POP) && (cnt <= {1'b0, last_idx});

  assign mem_we   = (state == S_PUSH);
  assign mem_re   = issue;
  assign mem_addr = mem_we ? sp + SP_W'(1) : sp;
  assign sp_out   = sp;
  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign ret_pc     = {mode_q ? b_up : FIXED_PAGE, b_hi, b_lo};
  assign ret_status = b_st;

  always_comb begin
    mem_wdata = 8'h00;
    if (mode_q) begin
      case (cnt[1:0])
        2'd0:    mem_wdata = st_q;
        2'd1:    mem_wdata = pc_q[23:16];
        2'd2:    mem_wdata = pc_q[7:0];
        default: mem_wdata = pc_q[15:8];
      endcase
    end else begin
      mem_wdata = cnt[0] ? pc_q[15:8] : pc_q[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= 1'b0;
      sp     <= SP_RESET;
      cnt    <= '0;
      pc_q   <= '0;
      st_q   <= '0;
      rv     <= 1'b0;
      ridx   <= '0;
      b_hi   <= '0;
      b_lo   <= '0;
      b_up   <= '0;
      b_st   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rv     <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (irq_take) begin
            state  <= S_PUSH;
            mode_q <= mode_sel;
            pc_q   <= pc_in;
            st_q   <= status_in;
          end else if (reti_req) begin
            state  <= S_POP;
            mode_q <= mode_sel;
            b_st   <= status_in;
          end else if (sp_load) begin
            sp <= sp_load_val;
          end
        end
        S_PUSH: begin
          sp  <= sp + SP_W'(1);
          cnt <= cnt + 3'd1;
          if (cnt[1:0] == last_idx) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_POP: begin
          if (issue) begin
            sp   <= sp - SP_W'(1);
            cnt  <= cnt + 3'd1;
            rv   <= 1'b1;
            ridx <= cnt[1:0];
          end
          if (rv) begin
            case (ridx)
              2'd0:    b_hi <= mem_rdata;
              2'd1:    b_lo <= mem_rdata;
              2'd2:    b_up <= mem_rdata;
              default: b_st <= mem_rdata;
            endcase
            if (ridx == last_idx) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R5
  AST_WRITE_BUMPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) + SP_W'(1))); // R5
  AST_READ_DROPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp_out == $past(sp_out) - SP_W'(1))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re); // R6
  AST_SP_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_we && !mem_re |=> $stable(sp_out)); // R7

endmodule

// File: tb/ctx_stack_seq_tb.sv
module ctx_stack_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_take = 1'b0, reti_req = 1'b0, mode_sel = 1'b0, sp_load = 1'b0;
  logic [23:0] pc_in = '0;
  logic [7:0]  status_in = '0;
  logic [15:0] sp_load_val = '0;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] mem_addr, sp_out;
  logic [7:0]  mem_wdata, ret_status;
  logic [7:0]  mem_rdata = '0;
  logic [23:0] ret_pc;

  logic [7:0] mem [256];
  int checks = 0, errors = 0, cycles = 0, wr_count = 0, rd_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_we) begin mem[mem_addr[7:0]] <= mem_wdata; wr_count <= wr_count + 1; end
    if (mem_re) begin mem_rdata <= mem[mem_addr[7:0]]; rd_count <= rd_count + 1; end
  end

  ctx_stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .reti_req(reti_req),
    .mode_sel(mode_sel), .pc_in(pc_in), .status_in(status_in),
    .sp_load(sp_load), .sp_load_val(sp_load_val),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp_out(sp_out), .busy(busy), .done(done),
    .ret_pc(ret_pc), .ret_status(ret_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // waits for done; returns number of busy cycles seen
  task automatic wait_done(output int nbusy);
    int guard = 0;
    nbusy = 0;
    while (!done) begin
      if (busy) nbusy++;
      @(negedge clk);
      guard++;
      if (guard > 50) begin
        errors++;
        $display("FAIL R6: done never seen, actual 0 expected 1");
        finish_run();
      end
    end
  endtask

  task automatic do_save(input logic m, input logic [23:0] pc, input logic [7:0] st, output int nbusy);
    irq_take = 1'b1; mode_sel = m; pc_in = pc; status_in = st;
    @(negedge clk);
    irq_take = 1'b0;
    wait_done(nbusy);
  endtask

  task automatic do_return(input logic m, input logic [7:0] st, output int nbusy);
    reti_req = 1'b1; mode_sel = m; status_in = st;
    @(negedge clk);
    reti_req = 1'b0;
    wait_done(nbusy);
  endtask

  task automatic test_reset();
    chk("R8 reset sp", sp_out, 16'h0007);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset done", done, 0);
  endtask

  task automatic test_short();
    int nb;
    do_save(1'b0, 24'h123456, 8'hC3, nb);
    chk("R1 sp after save", sp_out, 16'h0009);
    chk("R1 byte at sp+1", mem[8], 8'h56);
    chk("R1 byte at sp+2", mem[9], 8'h34);
    chk("R6 save busy cycles", nb, 2);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    do_return(1'b0, 8'h77, nb);
    chk("R2 ret_pc fixed page", ret_pc, 24'hFF3456);
    chk("R2 ret_status from input", ret_status, 8'h77);
    chk("R5 sp after return", sp_out, 16'h0007);
    chk("R6 return busy cycles", nb, 3);
  endtask

  task automatic test_long();
    int nb;
    do_save(1'b1, 24'hABCDEF, 8'h5A, nb);
    chk("R3 sp after save", sp_out, 16'h000B);
    chk("R3 byte1 status", mem[8], 8'h5A);
    chk("R3 byte2 pc_up", mem[9], 8'hAB);
    chk("R3 byte3 pc_lo", mem[10], 8'hEF);
    chk("R3 byte4 pc_hi", mem[11], 8'hCD);
    chk("R6 long save busy", nb, 4);
    do_return(1'b1, 8'h00, nb);
    chk("R4 ret_pc full", ret_pc, 24'hABCDEF);
    chk("R4 ret_status", ret_status, 8'h5A);
    chk("R5 sp after return", sp_out, 16'h0007);
    chk("R6 long return busy", nb, 5);
  endtask

  task automatic test_nested();
    int nb;
    do_save(1'b0, 24'h42BEEF, 8'h11, nb);
    do_save(1'b1, 24'h9A0102, 8'hE4, nb);
    chk("R5 nested sp", sp_out, 16'h000D);
    do_return(1'b1, 8'h00, nb);
    chk("R4 nested long pc", ret_pc, 24'h9A0102);
    chk("R4 nested long status", ret_status, 8'hE4);
    do_return(1'b0, 8'h3C, nb);
    chk("R2 nested short pc", ret_pc, 24'hFFBEEF);
    chk("R5 nested sp back", sp_out, 16'h0007);
  endtask

  task automatic test_ignore();
    int w0, nb;
    w0 = wr_count;
    irq_take = 1'b1; mode_sel = 1'b1; pc_in = 24'h010203; status_in = 8'h44;
    @(negedge clk);
    irq_take = 1'b0; mode_sel = 1'b0;
    reti_req = 1'b1; sp_load = 1'b1; sp_load_val = 16'h0080;
    @(negedge clk);
    reti_req = 1'b0; irq_take = 1'b1;
    @(negedge clk);
    irq_take = 1'b0; sp_load = 1'b0;
    wait_done(nb);
    chk("R7 mode sampled at start, 4 writes", wr_count - w0, 4);
    chk("R7 sp unaffected by busy requests", sp_out, 16'h000B);
    @(negedge clk);
    chk("R7 no new sequence", busy, 0);
    do_return(1'b1, 8'h00, nb);
    chk("R7 frame intact", ret_pc, 24'h010203);
  endtask

  task automatic test_load_and_priority();
    int nb, r0;
    sp_load = 1'b1; sp_load_val = 16'h0040;
    @(negedge clk);
    sp_load = 1'b0;
    chk("R8 load idle", sp_out, 16'h0040);
    r0 = rd_count;
    irq_take = 1'b1; reti_req = 1'b1; sp_load = 1'b1; sp_load_val = 16'h0090;
    mode_sel = 1'b0; pc_in = 24'h00ABCD;
    @(negedge clk);
    irq_take = 1'b0; reti_req = 1'b0; sp_load = 1'b0;
    wait_done(nb);
    chk("R7 save wins over return", sp_out, 16'h0042);
    chk("R7 no reads", rd_count - r0, 0);
    chk("R8 load loses to request", mem[8'h41], 8'hCD);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_short();
    test_long();
    test_nested();
    test_ignore();
    test_load_and_priority();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    wait (cycles > WD_LIMIT);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WD_LIMIT);
    finish_run();
  end
endmodule